// File: doc/BRIEF.md
# I2C General Call Response Controller

This block handles the address phase and the acknowledge decisions of an I2C bus interface for a general call. It follows START, STOP and SCL edges on the already filtered bus lines. It recognises a general call, which is a first byte of all zeros followed by a second address byte. Control inputs decide whether the block acknowledges the call. A status output reports that a general call was accepted. A transfer interrupt is raised after the eighth or after the ninth falling SCL edge of a byte, and while it is pending the block holds SCL low.

The block can also act as one of two masters that send a general call at the same moment. It then drives the zero byte and a second byte of its own onto SDA, most significant bit first. If it sees SDA low while it releases the line, it drops to slave reception of the winning master's byte. What happens to the general-call status and to the interrupt point after that depends on the acknowledge enable.

Top module: `gc_call_ctrl`

## Requirements
- R1: After reset the SDA and SCL pull-downs, the interrupt, the general-call status, the lost-arbitration status and the master status are all 0.
- R2: As a slave, a first byte of 0x00 is acknowledged (SDA low during the ninth bit) and sets the general-call status when the acknowledge enable is 1 at the eighth falling edge. When the enable is 0 the byte is not acknowledged and the status stays 0.
- R3: As a slave, a first byte other than 0x00 gets no acknowledge and no interrupt, and the general-call status stays 0 until the next START or STOP.
- R4: The interrupt is raised after the ninth falling SCL edge of a byte if the edge-select input is 0 at that edge, and after the eighth if it is 1 at that edge. This happens only while the block is master or has been addressed.
- R5: For every byte after the first, the block's acknowledge follows the data-acknowledge input as it stands during the ninth bit, so software may change it while the eighth-edge interrupt is pending.
- R6: A pending interrupt holds SCL low. It stays pending until a one-cycle clear pulse, which releases SCL.
- R7: The received byte output holds the eight bits clocked in, MSB first, from the eighth falling edge onward. The last-received-bit output takes the SDA level at the ninth rising SCL edge (0 = acknowledge).
- R8: When master-select is 1 at START, the block drives 0x00 and then its second-byte input onto SDA, MSB first. It never acknowledges its own bytes, and it takes interrupts on both bytes.
- R9: If, as master, the block releases SDA but samples it low at a rising SCL edge, it clears the master status, sets the sticky lost-arbitration status, stops driving SDA and goes on receiving and acknowledging as a slave.
- R10: After arbitration is lost with the acknowledge enable at 1, the general-call status remains 1.
- R11: After arbitration is lost with the acknowledge enable at 0, the general-call status becomes 1 at the loss. The interrupt is raised at the eighth falling edge of that byte whatever the edge-select input is, and the status returns to 0 at that byte's ninth falling edge.
- R12: A STOP clears the general-call, lost-arbitration and master statuses. A START or repeated START restarts decoding at the first byte and clears the general-call status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL bus level |
| sda_i | input | 1 | Filtered SDA bus level |
| sda_lo_o | output | 1 | 1 pulls SDA low |
| scl_lo_o | output | 1 | 1 holds SCL low (stretch) |
| gc_ack_en_i | input | 1 | Acknowledge a general call |
| irq_at8_i | input | 1 | 1 moves the interrupt to the eighth falling edge |
| data_ack_en_i | input | 1 | Acknowledge bytes after the first |
| master_sel_i | input | 1 | Act as master for the transfer begun by the next START |
| second_byte_i | input | BYTE_W | Second general-call byte sent as master |
| irq_clr_i | input | 1 | One-cycle pulse clearing the interrupt |
| irq_o | output | 1 | Transfer interrupt pending |
| gca_o | output | 1 | General-call status |
| al_o | output | 1 | Sticky lost-arbitration status |
| lrb_o | output | 1 | Last received bit (acknowledge level) |
| master_o | output | 1 | Block is currently master |
| rx_byte_o | output | BYTE_W | Last byte shifted in from SDA |

## Verification
The hardest situation to reach is an arbitration loss inside the second general-call byte. It needs two masters driving the same SCL and SDA bit-synchronously, where they agree on the whole zero byte and part of the second byte and then differ in a bit the block releases. The bench takes the role of the competing master. It drives the wired-AND bus so that the block's own pull-down and the bench's bit are combined, and it sends 0x0C against the block's 0x0F. The loss therefore falls in the seventh bit, and the general-call status can be probed right after that bit, before the eighth-edge interrupt. Both settings of the acknowledge enable are driven through this loss.

// File: rtl/gc_pkg.sv
package gc_pkg;

    // one-cycle bus condition strobes
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    // controller state
    typedef struct packed {
        logic [1:0] byte_idx;   // 0 = first byte, 1 = second, 2/3 = data
        logic       skip;       // not a general call, ignore until START/STOP
        logic       master;
        logic       addressed;
        logic       gca;
        logic       al;
        logic       al_en0;     // lost with acknowledge enable clear
        logic       irq;
        logic       lrb;
        logic       tx_drv;     // master data bit pulls SDA low
        logic       ack_slot;   // between 8th and 9th falling edge
    } ctl_t;

endpackage

// File: rtl/gc_bus_events.sv
module gc_bus_events
    import gc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d     = smp_q;
        smp_d.scl = scl_i;
        smp_d.sda = sda_i;

        ev_o.rise  = scl_i & ~smp_q.scl;
        ev_o.fall  = ~scl_i & smp_q.scl;
        ev_o.start = scl_i & smp_q.scl & smp_q.sda & ~sda_i;
        ev_o.stop  = scl_i & smp_q.scl & ~smp_q.sda & sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            smp_q <= smp_d;
        end
    end

endmodule

// File: rtl/gc_bit_track.sv
module gc_bit_track
    import gc_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  bus_ev_t                             ev_i,
    input  logic                                sda_i,
    output logic [$clog2(BYTE_W + 2) - 1:0]     bitn_o,
    output logic [BYTE_W-1:0]                   rx_o,
    output logic                                step_o,
    output logic                                data_rise_o,
    output logic                                ack_rise_o,
    output logic                                edge8_o,
    output logic                                edge9_o
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] N_DATA = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] N_ACK  = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        logic              framed;
        logic [CNT_W-1:0]  bitn;    // rising edges seen in this byte
        logic [BYTE_W-1:0] rx;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;

        step_o      = trk_q.framed & ev_i.fall & (trk_q.bitn < N_DATA);
        data_rise_o = trk_q.framed & ev_i.rise & (trk_q.bitn < N_DATA);
        ack_rise_o  = trk_q.framed & ev_i.rise & (trk_q.bitn == N_DATA);
        edge8_o     = trk_q.framed & ev_i.fall & (trk_q.bitn == N_DATA);
        edge9_o     = trk_q.framed & ev_i.fall & (trk_q.bitn == N_ACK);

        if (ev_i.start) begin
            trk_d.framed = 1'b1;
            trk_d.bitn   = '0;
        end else if (ev_i.stop) begin
            trk_d.framed = 1'b0;
            trk_d.bitn   = '0;
        end else if (trk_q.framed) begin
            if (data_rise_o) begin
                trk_d.rx = {trk_q.rx[BYTE_W-2:0], sda_i};
            end
            if (ev_i.rise && trk_q.bitn != N_ACK) begin
                trk_d.bitn = trk_q.bitn + 1'b1;
            end
            if (edge9_o) begin
                trk_d.bitn = '0;
            end
        end

        bitn_o = trk_q.bitn;
        rx_o   = trk_q.rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/gc_sda_drive.sv
module gc_sda_drive (
    input  logic tx_drv_i,
    input  logic ack_slot_i,
    input  logic master_i,
    input  logic addressed_i,
    input  logic first_byte_i,
    input  logic data_ack_en_i,
    output logic sda_lo_o
);

    logic ack_want;

    always_comb begin
        // first byte is acknowledged once addressed; later bytes follow software
        ack_want = first_byte_i ? 1'b1 : data_ack_en_i;
        sda_lo_o = tx_drv_i | (ack_slot_i & ~master_i & addressed_i & ack_want);
    end

endmodule

// File: rtl/gc_call_ctrl.sv
module gc_call_ctrl
    import gc_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_lo_o,
    output logic              scl_lo_o,
    input  logic              gc_ack_en_i,
    input  logic              irq_at8_i,
    input  logic              data_ack_en_i,
    input  logic              master_sel_i,
    input  logic [BYTE_W-1:0] second_byte_i,
    input  logic              irq_clr_i,
    output logic              irq_o,
    output logic              gca_o,
    output logic              al_o,
    output logic              lrb_o,
    output logic              master_o,
    output logic [BYTE_W-1:0] rx_byte_o
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 2);

    bus_ev_t           ev;
    logic [CNT_W-1:0]  bitn;
    logic [BYTE_W-1:0] rx;
    logic              step, data_rise, ack_rise, edge8, edge9;
    logic [BYTE_W-1:0] tx_src, tx_shift;
    logic              involved;
    ctl_t              ctl_d, ctl_q;

    gc_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    gc_bit_track #(.BYTE_W(BYTE_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .sda_i       (sda_i),
        .bitn_o      (bitn),
        .rx_o        (rx),
        .step_o      (step),
        .data_rise_o (data_rise),
        .ack_rise_o  (ack_rise),
        .edge8_o     (edge8),
        .edge9_o     (edge9)
    );

    gc_sda_drive u_drive (
        .tx_drv_i      (ctl_q.tx_drv),
        .ack_slot_i    (ctl_q.ack_slot),
        .master_i      (ctl_q.master),
        .addressed_i   (ctl_q.addressed),
        .first_byte_i  (ctl_q.byte_idx == 2'd0),
        .data_ack_en_i (data_ack_en_i),
        .sda_lo_o      (sda_lo_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tx_src   = (ctl_q.byte_idx == 2'd0) ? '0 : second_byte_i;
        tx_shift = tx_src << bitn;
        involved = 1'b0;

        if (irq_clr_i) begin
            ctl_d.irq = 1'b0;
        end

        if (ev.stop) begin
            ctl_d     = '0;
            ctl_d.lrb = ctl_q.lrb;
            ctl_d.irq = ctl_q.irq & ~irq_clr_i;
        end else if (ev.start) begin
            ctl_d.byte_idx  = 2'd0;
            ctl_d.skip      = 1'b0;
            ctl_d.master    = master_sel_i;
            ctl_d.addressed = 1'b0;
            ctl_d.gca       = 1'b0;
            ctl_d.al_en0    = 1'b0;
            ctl_d.tx_drv    = 1'b0;
            ctl_d.ack_slot  = 1'b0;
        end else begin
            // master places the next data bit while SCL is low
            if (step) begin
                ctl_d.tx_drv = ctl_q.master & (ctl_q.byte_idx <= 2'd1) & ~tx_shift[BYTE_W-1];
            end

            // lost arbitration: released line read back low
            if (data_rise && ctl_q.master && !ctl_q.tx_drv && !sda_i) begin
                ctl_d.master    = 1'b0;
                ctl_d.al        = 1'b1;
                ctl_d.tx_drv    = 1'b0;
                ctl_d.addressed = 1'b1;
                if (!gc_ack_en_i) begin
                    ctl_d.gca    = 1'b1;
                    ctl_d.al_en0 = 1'b1;
                end
            end

            if (edge8 && !ctl_q.skip) begin
                ctl_d.tx_drv = 1'b0;
                if (ctl_q.byte_idx == 2'd0) begin
                    if (rx == '0) begin
                        if (gc_ack_en_i) begin
                            ctl_d.gca       = 1'b1;
                            ctl_d.addressed = 1'b1;
                        end
                    end else if (!ctl_q.master) begin
                        ctl_d.skip = 1'b1;
                    end
                end
                ctl_d.ack_slot = ~ctl_d.skip;
                involved       = (ctl_d.master | ctl_d.addressed) & ~ctl_d.skip;
                if (involved && (irq_at8_i || ctl_q.al_en0)) begin
                    ctl_d.irq = 1'b1;
                end
            end

            if (ack_rise && !ctl_q.skip && (ctl_q.master || ctl_q.addressed)) begin
                ctl_d.lrb = sda_i;
            end

            if (edge9 && !ctl_q.skip) begin
                ctl_d.ack_slot = 1'b0;
                if ((ctl_q.master || ctl_q.addressed) && !irq_at8_i) begin
                    ctl_d.irq = 1'b1;
                end
                if (ctl_q.al_en0) begin
                    ctl_d.gca    = 1'b0;
                    ctl_d.al_en0 = 1'b0;
                end
                if (ctl_q.byte_idx != 2'd3) begin
                    ctl_d.byte_idx = ctl_q.byte_idx + 2'd1;
                end
                // first bit of the second byte goes out right after the ack
                ctl_d.tx_drv = ctl_q.master & (ctl_q.byte_idx == 2'd0) & ~second_byte_i[BYTE_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scl_lo_o  = ctl_q.irq;
    assign irq_o     = ctl_q.irq;
    assign gca_o     = ctl_q.gca;
    assign al_o      = ctl_q.al;
    assign lrb_o     = ctl_q.lrb;
    assign master_o  = ctl_q.master;
    assign rx_byte_o = rx;

endmodule

// File: rtl/gc_resp_chk.sv
module gc_resp_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_lo_o,
    input logic irq_clr_i,
    input logic irq_o,
    input logic gca_o,
    input logic al_o,
    input logic master_o
);

    // R6: pending interrupt stays until cleared
    a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !irq_clr_i |=> irq_o);

    // R4: interrupt only appears just after an SCL fall
    a_r4_irq_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !scl_i && $past(scl_i, 2));

    // R9: losing arbitration ends master status
    a_r9_loss_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_o) |-> !master_o);

    // R10/R11: general call status is 1 at the moment of loss
    a_r10_gca_at_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_o) |-> gca_o);

    // R12: STOP clears the statuses
    a_r12_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i && $past(scl_i) && sda_i && !$past(sda_i) |=> !gca_o && !al_o && !master_o);

    // R8: SDA pull-down only starts while SCL is low
    a_r8_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_lo_o) |-> !scl_i);

endmodule

bind gc_call_ctrl gc_resp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lo_o  (sda_lo_o),
    .irq_clr_i (irq_clr_i),
    .irq_o     (irq_o),
    .gca_o     (gca_o),
    .al_o      (al_o),
    .master_o  (master_o)
);

// File: tb/test_gc_call_ctrl.sv
module test_gc_call_ctrl;

    localparam int CLK_P = 10;
    localparam int HALF  = 4;
    localparam int WD    = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       gc_ack_en = 1'b0, irq_at8 = 1'b0, data_ack_en = 1'b0;
    logic       master_sel = 1'b0, irq_clr = 1'b0;
    logic [7:0] second_byte = 8'h00;
    logic       sda_lo, scl_lo, irq, gca, al, lrb, mst;
    logic [7:0] rx_byte;
    logic       scl_bus, sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always #(CLK_P / 2) clk = ~clk;

    assign scl_bus = scl_m & ~scl_lo;
    assign sda_bus = sda_m & ~sda_lo;

    gc_call_ctrl i_gc_call_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_bus),
        .sda_i         (sda_bus),
        .sda_lo_o      (sda_lo),
        .scl_lo_o      (scl_lo),
        .gc_ack_en_i   (gc_ack_en),
        .irq_at8_i     (irq_at8),
        .data_ack_en_i (data_ack_en),
        .master_sel_i  (master_sel),
        .second_byte_i (second_byte),
        .irq_clr_i     (irq_clr),
        .irq_o         (irq),
        .gca_o         (gca),
        .al_o          (al),
        .lrb_o         (lrb),
        .master_o      (mst),
        .rx_byte_o     (rx_byte)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        tick(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(2);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b0;
        tick(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(2);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b1;
        tick(HALF);
    endtask

    task automatic bit_cycle(input logic b, output logic seen);
        sda_m = b;
        tick(2);
        scl_m = 1'b1;
        tick(HALF);
        seen = sda_bus;
        scl_m = 1'b0;
        tick(HALF);
    endtask

    task automatic send_bits(input logic [7:0] d, input int hi, input int lo,
                             inout logic [7:0] seen);
        for (int i = hi; i >= lo; i--) begin
            logic s;
            bit_cycle(d[i], s);
            seen[i] = s;
        end
    endtask

    // behavioural expectation for one acknowledge bit plus the 9th-edge interrupt
    task automatic ack_phase(input string tag, input logic exp_ack, input logic exp_irq9);
        logic s;
        bit_cycle(1'b1, s);
        check({tag, " ack level"}, s, exp_ack);
        check({tag, " irq at 9th edge"}, irq, exp_irq9);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD && !done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        logic       s;
        seen = '0;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        check("R1 sda_lo", sda_lo, 0);
        check("R1 scl_lo", scl_lo, 0);
        check("R1 irq", irq, 0);
        check("R1 gca", gca, 0);
        check("R1 al", al, 0);
        check("R1 master", mst, 0);

        // ---- slave, enable set, interrupt at 9th edge
        gc_ack_en = 1; irq_at8 = 0; data_ack_en = 1;
        bus_start();
        send_bits(8'h00, 7, 0, seen);
        check("R4 no irq at 8th when select 0", irq, 0);
        ack_phase("R2 slave gc", 1'b0, 1'b1);
        check("R2 gca set", gca, 1);
        // R6 stretch: raise SCL while interrupt pending
        sda_m = 1'b0;
        tick(2);
        scl_m = 1'b1;
        tick(6);
        check("R6 scl held low", scl_bus, 0);
        clr_irq();
        tick(HALF);
        check("R6 scl released", scl_bus, 1);
        scl_m = 1'b0;
        tick(HALF);
        send_bits(8'h04, 6, 0, seen);
        check("R7 rx byte", rx_byte, 8'h04);
        ack_phase("R5 data ack", 1'b0, 1'b1);
        check("R7 lrb ack", lrb, 0);
        clr_irq();
        // repeated START then non-general address
        bus_start();
        check("R12 start clears gca", gca, 0);
        send_bits(8'h52, 7, 0, seen);
        check("R3 no irq at 8th", irq, 0);
        ack_phase("R3 other address", 1'b1, 1'b0);
        check("R3 gca stays 0", gca, 0);
        bus_stop();

        // ---- slave, enable clear
        gc_ack_en = 0;
        bus_start();
        send_bits(8'h00, 7, 0, seen);
        ack_phase("R2 enable clear", 1'b1, 1'b0);
        check("R2 gca clear", gca, 0);
        bus_stop();

        // ---- slave, enable set, interrupt at 8th edge
        gc_ack_en = 1; irq_at8 = 1; data_ack_en = 1;
        bus_start();
        send_bits(8'h00, 7, 0, seen);
        check("R4 irq at 8th", irq, 1);
        clr_irq();
        ack_phase("R4 select 1 first byte", 1'b0, 1'b0);
        send_bits(8'h04, 7, 0, seen);
        check("R4 irq at 8th second byte", irq, 1);
        check("R7 rx at 8th edge", rx_byte, 8'h04);
        data_ack_en = 0; irq_at8 = 0;
        clr_irq();
        ack_phase("R5 nack chosen at 8th", 1'b1, 1'b1);
        check("R7 lrb nack", lrb, 1);
        clr_irq();
        bus_stop();
        check("R12 stop clears gca", gca, 0);

        // ---- master, enable clear, no loss; bench releases to observe
        gc_ack_en = 0; irq_at8 = 0; data_ack_en = 1;
        master_sel = 1; second_byte = 8'h06;
        bus_start();
        master_sel = 0;
        seen = '0;
        send_bits(8'hFF, 7, 0, seen);
        check("R8 first byte driven", seen, 8'h00);
        ack_phase("R8 master first byte", 1'b1, 1'b1);
        check("R8 gca clear", gca, 0);
        clr_irq();
        send_bits(8'hFF, 7, 0, seen);
        check("R8 second byte driven", seen, 8'h06);
        check("R8 no irq at 8th", irq, 0);
        ack_phase("R8 no self ack", 1'b1, 1'b1);
        check("R8 still master", mst, 1);
        check("R9 no loss", al, 0);
        clr_irq();
        bus_stop();
        check("R12 stop clears master", mst, 0);

        // ---- master, enable set, loss in second byte
        gc_ack_en = 1; master_sel = 1; second_byte = 8'h0F;
        bus_start();
        master_sel = 0;
        send_bits(8'h00, 7, 0, seen);
        ack_phase("R8 enable set master", 1'b1, 1'b1);
        check("R8 gca with enable", gca, 1);
        clr_irq();
        send_bits(8'h0C, 7, 1, seen);
        check("R9 al set", al, 1);
        check("R9 master dropped", mst, 0);
        check("R10 gca kept", gca, 1);
        send_bits(8'h0C, 0, 0, seen);
        check("R9 rx winner byte", rx_byte, 8'h0C);
        check("R10 no irq at 8th", irq, 0);
        ack_phase("R9 slave ack after loss", 1'b0, 1'b1);
        check("R10 gca after byte", gca, 1);
        clr_irq();
        bus_stop();

        // ---- master, enable clear, loss in second byte
        gc_ack_en = 0; master_sel = 1; second_byte = 8'h0F;
        bus_start();
        master_sel = 0;
        send_bits(8'h00, 7, 0, seen);
        ack_phase("R8 enable clear master", 1'b1, 1'b1);
        clr_irq();
        send_bits(8'h0C, 7, 1, seen);
        check("R11 gca set at loss", gca, 1);
        check("R9 al sticky", al, 1);
        send_bits(8'h0C, 0, 0, seen);
        check("R11 forced irq at 8th", irq, 1);
        clr_irq();
        ack_phase("R11 ack after loss", 1'b0, 1'b1);
        check("R11 gca cleared at 9th", gca, 0);
        clr_irq();
        bus_stop();
        check("R12 stop clears al", al, 0);
        bit_cycle(1'b1, s);
        check("R12 idle after stop", irq, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule